// File: doc/BRIEF.md
# Programmable Vertical Sync Start Generator

This block sets where, inside each field of an interlaced 525-line timing stream, the vertical sync output rises. A line counter, a first-or-second-half indicator and a half-line strobe come from the upstream timing chain, together with an odd/even field flag. The start point is a signed shift of a fixed nominal line (advance or delay by a 5-bit count). Per field type, an optional one-line delay and an optional half-line delay are then added, in that order. The pulse falls at a programmable end line. One registered state bit drives both the external sync pin and the vertical flag placed in the embedded timing codes, so the two cannot drift apart.

All positions are in half-line units: `hpos = 2*line_idx + half_sel`. A field starts on the strobe with `line_idx = 0` and `half_sel = 0`. Odd fields are 263 lines long and even fields 262. The configuration inputs are sampled into a shadow copy only at that field-start strobe. A setting changed partway through a field therefore never cuts a pulse short and never produces a second one.

Top module: `vsync_begin_gen`

## Requirements
- R1: When reset is released, `vs_out` and `v_flag` are 0. The shadow configuration holds: offset 5, advance selected, no one-line or half-line delays, end line 10, odd field. It is used until the first field-start strobe.
- R2: The start half-line is `2*(NOM_LINE - ofs)` when `cfg_advance = 1` and `2*(NOM_LINE + ofs)` when it is 0. The default `NOM_LINE` is 4. The output is 1 in the cycle after the strobe whose `hpos` equals the start half-line.
- R3: `cfg_ld_odd` (on odd fields) and `cfg_ld_even` (on even fields) each add 2 half-lines to the start. The control for the other field type has no effect.
- R4: `cfg_hd_odd` and `cfg_hd_even` each add 1 half-line to the start, on their own field type only. The control for the other field type has no effect.
- R5: A negative start position wraps by adding 526 on odd fields (`field_odd = 1`) and 524 on even fields.
- R6: The output goes to 0 in the cycle after the strobe whose `hpos` equals `2*(NOM_LINE + cfg_end_line)`, unless that half-line is also the start half-line.
- R7: `v_flag` equals `vs_out` in every cycle.
- R8: The configuration and the field flag are captured only at the field-start strobe. Changes between field starts have no effect until the next field.
- R9: The output changes only in the cycle after a strobe. It holds in every cycle that follows a cycle with `hl_stb = 0`.
- R10: When the start and end half-lines coincide, the start wins and the output is 1 after that strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hl_stb | input | 1 | Half-line strobe, one cycle per half-line |
| line_idx | input | LINE_W | Line number within the field, from 0 |
| half_sel | input | 1 | 0 for the first half of the line, 1 for the second half |
| field_odd | input | 1 | 1 while an odd field is in progress |
| cfg_ofs | input | 5 | Start shift magnitude in lines |
| cfg_advance | input | 1 | 1 moves the start earlier, 0 moves it later |
| cfg_ld_odd | input | 1 | One-line extra start delay, odd fields |
| cfg_ld_even | input | 1 | One-line extra start delay, even fields |
| cfg_hd_odd | input | 1 | Half-line extra start delay, odd fields |
| cfg_hd_even | input | 1 | Half-line extra start delay, even fields |
| cfg_end_line | input | 5 | End position in lines past the nominal line |
| vs_out | output | 1 | Vertical sync output |
| v_flag | output | 1 | Vertical flag for the embedded timing codes |

## Verification
The assertions assume that the line counter and half indicator describe a well-formed field. Half-lines advance by one per strobe, the counter never exceeds the length of the current field type, and the field flag changes only at a field start. The stimulus always walks complete fields in half-line order, or a tail of one field after reset. It alternates field types and may insert idle cycles between strobes. All configuration changes fall between strobes, and one deliberate change falls partway through a field.

// File: rtl/vsb_pkg.sv
package vsb_pkg;
    localparam int OFS_W = 5;
    localparam int END_W = 5;

    typedef struct packed {
        logic [OFS_W-1:0] ofs;
        logic             advance;
        logic             ld_odd;
        logic             ld_even;
        logic             hd_odd;
        logic             hd_even;
        logic [END_W-1:0] end_line;
    } vsb_cfg_t;

    localparam vsb_cfg_t CFG_RESET = '{
        ofs:      OFS_W'(5),
        advance:  1'b1,
        ld_odd:   1'b0,
        ld_even:  1'b0,
        hd_odd:   1'b0,
        hd_even:  1'b0,
        end_line: END_W'(10)
    };

    typedef struct packed {
        vsb_cfg_t cfg;
        logic     odd;
        logic     vs;
    } vsb_state_t;
endpackage

// File: rtl/vsb_cfg_select.sv
module vsb_cfg_select
    import vsb_pkg::*;
(
    input  logic     field_start,
    input  vsb_cfg_t live_cfg,
    input  logic     live_odd,
    input  vsb_cfg_t held_cfg,
    input  logic     held_odd,
    output vsb_cfg_t eff_cfg,
    output logic     eff_odd
);
    // At a field start the fresh settings govern that same strobe.
    always_comb begin
        if (field_start) begin
            eff_cfg = live_cfg;
            eff_odd = live_odd;
        end else begin
            eff_cfg = held_cfg;
            eff_odd = held_odd;
        end
    end
endmodule

// File: rtl/vsb_begin_calc.sv
module vsb_begin_calc
    import vsb_pkg::*;
#(
    parameter int HPOS_W     = 11,
    parameter int NOM_LINE   = 4,
    parameter int ODD_LINES  = 263,
    parameter int EVEN_LINES = 262
) (
    input  vsb_cfg_t          cfg,
    input  logic              odd,
    output logic [HPOS_W-1:0] beg_pos
);
    localparam int SW = HPOS_W + 2;
    localparam logic [SW-1:0] ODD_SPAN  = SW'(2 * ODD_LINES);
    localparam logic [SW-1:0] EVEN_SPAN = SW'(2 * EVEN_LINES);

    logic [SW-1:0] nom_v, ofs_v, line_v, pos_v, wrap_v;
    logic          ld_sel, hd_sel;

    always_comb begin
        nom_v  = SW'(NOM_LINE);
        ofs_v  = SW'(cfg.ofs);
        ld_sel = odd ? cfg.ld_odd : cfg.ld_even;
        hd_sel = odd ? cfg.hd_odd : cfg.hd_even;
        // signed shift first, then whole-line, then half-line delay
        line_v = cfg.advance ? (nom_v - ofs_v) : (nom_v + ofs_v);
        pos_v  = (line_v << 1) + {{(SW-2){1'b0}}, ld_sel, hd_sel};
        if (pos_v[SW-1]) begin
            wrap_v = pos_v + (odd ? ODD_SPAN : EVEN_SPAN);
        end else begin
            wrap_v = pos_v;
        end
        beg_pos = wrap_v[HPOS_W-1:0];
    end
endmodule

// File: rtl/vsb_end_calc.sv
module vsb_end_calc
    import vsb_pkg::*;
#(
    parameter int HPOS_W   = 11,
    parameter int NOM_LINE = 4
) (
    input  vsb_cfg_t          cfg,
    output logic [HPOS_W-1:0] end_pos
);
    localparam int SW = HPOS_W + 1;

    logic [SW-1:0] line_v;

    always_comb begin
        line_v  = SW'(NOM_LINE) + SW'(cfg.end_line);
        end_pos = HPOS_W'(line_v << 1);
    end
endmodule

// File: rtl/vsync_begin_gen.sv
module vsync_begin_gen
    import vsb_pkg::*;
#(
    parameter int LINE_W     = 10,
    parameter int NOM_LINE   = 4,
    parameter int ODD_LINES  = 263,
    parameter int EVEN_LINES = 262
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 hl_stb,
    input  logic [LINE_W-1:0]    line_idx,
    input  logic                 half_sel,
    input  logic                 field_odd,
    input  logic [OFS_W-1:0]     cfg_ofs,
    input  logic                 cfg_advance,
    input  logic                 cfg_ld_odd,
    input  logic                 cfg_ld_even,
    input  logic                 cfg_hd_odd,
    input  logic                 cfg_hd_even,
    input  logic [END_W-1:0]     cfg_end_line,
    output logic                 vs_out,
    output logic                 v_flag
);
    localparam int HPOS_W = LINE_W + 1;

    vsb_state_t        st_d, st_q;
    vsb_cfg_t          live_cfg, eff_cfg;
    logic              eff_odd;
    logic              field_start;
    logic [HPOS_W-1:0] hpos, beg_pos, end_pos;

    assign live_cfg = '{
        ofs:      cfg_ofs,
        advance:  cfg_advance,
        ld_odd:   cfg_ld_odd,
        ld_even:  cfg_ld_even,
        hd_odd:   cfg_hd_odd,
        hd_even:  cfg_hd_even,
        end_line: cfg_end_line
    };
    assign hpos        = {line_idx, half_sel};
    assign field_start = hl_stb && (line_idx == '0) && !half_sel;

    vsb_cfg_select u_sel (
        .field_start (field_start),
        .live_cfg    (live_cfg),
        .live_odd    (field_odd),
        .held_cfg    (st_q.cfg),
        .held_odd    (st_q.odd),
        .eff_cfg     (eff_cfg),
        .eff_odd     (eff_odd)
    );

    vsb_begin_calc #(
        .HPOS_W     (HPOS_W),
        .NOM_LINE   (NOM_LINE),
        .ODD_LINES  (ODD_LINES),
        .EVEN_LINES (EVEN_LINES)
    ) u_beg (
        .cfg     (eff_cfg),
        .odd     (eff_odd),
        .beg_pos (beg_pos)
    );

    vsb_end_calc #(
        .HPOS_W   (HPOS_W),
        .NOM_LINE (NOM_LINE)
    ) u_end (
        .cfg     (eff_cfg),
        .end_pos (end_pos)
    );

    always_comb begin
        st_d = st_q;
        if (field_start) begin
            st_d.cfg = live_cfg;
            st_d.odd = field_odd;
        end
        if (hl_stb) begin
            if (hpos == end_pos) st_d.vs = 1'b0;
            // a start on the same half-line overrides the end
            if (hpos == beg_pos) st_d.vs = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{cfg: CFG_RESET, odd: 1'b1, vs: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign vs_out = st_q.vs;
    assign v_flag = st_q.vs;
endmodule

// File: rtl/vsb_checker.sv
module vsb_checker #(
    parameter int HPOS_W     = 11,
    parameter int ODD_LINES  = 263,
    parameter int EVEN_LINES = 262
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hl_stb,
    input logic [HPOS_W-1:0] hpos,
    input logic [HPOS_W-1:0] beg_pos,
    input logic [HPOS_W-1:0] end_pos,
    input logic              eff_odd,
    input logic              vs
);
    localparam logic [HPOS_W-1:0] ODD_SPAN  = HPOS_W'(2 * ODD_LINES);
    localparam logic [HPOS_W-1:0] EVEN_SPAN = HPOS_W'(2 * EVEN_LINES);

    AST_SET_ON_BEGIN: assert property (@(posedge clk) disable iff (!rst_n)
        (hl_stb && hpos == beg_pos) |=> vs);  // R2
    AST_CLEAR_ON_END: assert property (@(posedge clk) disable iff (!rst_n)
        (hl_stb && hpos == end_pos && hpos != beg_pos) |=> !vs);  // R6
    AST_HOLD_OFF_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !hl_stb |=> $stable(vs));  // R9
    AST_RISE_ONLY_AT_BEGIN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vs) |-> $past(hl_stb && hpos == beg_pos));  // R2
    AST_BEGIN_IN_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        beg_pos < (eff_odd ? ODD_SPAN : EVEN_SPAN));  // R5
endmodule

bind vsync_begin_gen vsb_checker #(
    .HPOS_W     (HPOS_W),
    .ODD_LINES  (ODD_LINES),
    .EVEN_LINES (EVEN_LINES)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .hl_stb  (hl_stb),
    .hpos    (hpos),
    .beg_pos (beg_pos),
    .end_pos (end_pos),
    .eff_odd (eff_odd),
    .vs      (vs_out)
);

// File: tb/vsync_begin_gen_test.sv
module vsync_begin_gen_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hl_stb = 1'b0;
    logic [9:0] line_idx = '0;
    logic       half_sel = 1'b0;
    logic       field_odd = 1'b1;
    logic [4:0] c_ofs = 5'd0;
    logic       c_adv = 1'b0;
    logic       c_ldo = 1'b0, c_lde = 1'b0, c_hdo = 1'b0, c_hde = 1'b0;
    logic [4:0] c_end = 5'd0;
    logic       vs_out, v_flag;

    always #10 clk = ~clk;

    vsync_begin_gen uut (
        .clk(clk), .rst_n(rst_n), .hl_stb(hl_stb), .line_idx(line_idx),
        .half_sel(half_sel), .field_odd(field_odd), .cfg_ofs(c_ofs),
        .cfg_advance(c_adv), .cfg_ld_odd(c_ldo), .cfg_ld_even(c_lde),
        .cfg_hd_odd(c_hdo), .cfg_hd_even(c_hde), .cfg_end_line(c_end),
        .vs_out(vs_out), .v_flag(v_flag)
    );

    int total = 0;
    int bad = 0;
    bit done = 0;

    typedef struct {
        bit    vs;
        int    hpos;
        string tag;
    } item_t;
    item_t exp_q[$];

    // reference shadow, reset values from R1
    int s_ofs = 5, s_adv = 1, s_ldo = 0, s_lde = 0, s_hdo = 0, s_hde = 0, s_end = 10, s_odd = 1;
    bit r_vs = 0;
    string cur_tag = "R2";
    int rise_pos = -1;
    int fall_pos = -1;

    task automatic chk(bit ok, string req, int act, int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic int exp_beg(int adv, int ofs, int ld, int hd, int odd);
        int p;
        p = 2 * (adv != 0 ? 4 - ofs : 4 + ofs) + 2 * ld + hd;
        if (p < 0) p += (odd != 0) ? 526 : 524;
        return p;
    endfunction

    task automatic push_item(int hp);
        item_t it;
        it.vs = r_vs; it.hpos = hp; it.tag = cur_tag;
        exp_q.push_back(it);
    endtask

    task automatic run_field(int odd, int first_line, bit gaps, int chg_line, int chg_ofs);
        int len = (odd != 0) ? 263 : 262;
        for (int ln = first_line; ln < len; ln++) begin
            for (int h = 0; h < 2; h++) begin
                int hp, ea, eo, el, eh, ee, eodd, bp;
                bit start;
                @(negedge clk);
                if (ln == chg_line && h == 0) c_ofs = 5'(chg_ofs);
                hl_stb = 1'b1; line_idx = 10'(ln); half_sel = 1'(h); field_odd = 1'(odd);
                hp = 2 * ln + h;
                start = (ln == 0 && h == 0);
                if (start) begin
                    ea = c_adv; eo = c_ofs; ee = c_end; eodd = odd;
                    el = odd != 0 ? c_ldo : c_lde; eh = odd != 0 ? c_hdo : c_hde;
                end else begin
                    ea = s_adv; eo = s_ofs; ee = s_end; eodd = s_odd;
                    el = s_odd != 0 ? s_ldo : s_lde; eh = s_odd != 0 ? s_hdo : s_hde;
                end
                bp = exp_beg(ea, eo, el, eh, eodd);
                if (hp == 2 * (4 + ee)) r_vs = 0;
                if (hp == bp) r_vs = 1;
                if (start) begin
                    s_adv = c_adv; s_ofs = c_ofs; s_ldo = c_ldo; s_lde = c_lde;
                    s_hdo = c_hdo; s_hde = c_hde; s_end = c_end; s_odd = odd;
                end
                push_item(hp);
                if (gaps && (hp % 3 == 0)) begin
                    @(negedge clk);
                    hl_stb = 1'b0;
                    push_item(hp);
                end
            end
        end
        @(negedge clk);
        hl_stb = 1'b0;
        push_item(2 * len - 1);
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic set_cfg(int adv, int ofs, int ldo, int lde, int hdo, int hde, int e);
        c_adv = 1'(adv); c_ofs = 5'(ofs); c_ldo = 1'(ldo); c_lde = 1'(lde);
        c_hdo = 1'(hdo); c_hde = 1'(hde); c_end = 5'(e);
    endtask

    // monitor: one expected item per cycle
    initial begin
        bit prev_vs = 0;
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                item_t it;
                it = exp_q.pop_front();
                chk(vs_out == it.vs, it.tag, int'(vs_out), int'(it.vs));
                chk(v_flag == vs_out, "R7", int'(v_flag), int'(vs_out));
                if (vs_out && !prev_vs) rise_pos = it.hpos;
                if (!vs_out && prev_vs) fall_pos = it.hpos;
            end
            prev_vs = vs_out;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            bad++; total++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        chk(vs_out == 0, "R1", int'(vs_out), 0);
        chk(v_flag == 0, "R1", int'(v_flag), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(vs_out == 0, "R1", int'(vs_out), 0);

        // R1: tail of an odd field with shadow defaults, live settings differ
        cur_tag = "R1";
        set_cfg(0, 0, 1, 1, 1, 1, 3);
        run_field(1, 255, 0, -1, 0);
        settle();
        chk(rise_pos == 524, "R1", rise_pos, 524);

        // R3 R4 R9: even field, even delays on, idle gaps between strobes
        cur_tag = "R9";
        set_cfg(0, 3, 0, 1, 0, 1, 2);
        rise_pos = -1; fall_pos = -1;
        run_field(0, 0, 1, -1, 0);
        settle();
        chk(rise_pos == 17, "R3", rise_pos, 17);
        chk(fall_pos == 12, "R6", fall_pos, 12);

        // R4: odd field, only odd half-line delay; even controls ignored
        cur_tag = "R4";
        set_cfg(0, 2, 0, 1, 1, 1, 0);
        rise_pos = -1; fall_pos = -1;
        run_field(1, 0, 0, -1, 0);
        settle();
        chk(rise_pos == 13, "R4", rise_pos, 13);
        chk(fall_pos == 8, "R6", fall_pos, 8);

        // R5: negative start wraps, even then odd
        cur_tag = "R5";
        set_cfg(1, 9, 1, 1, 0, 0, 0);
        rise_pos = -1;
        run_field(0, 0, 0, -1, 0);
        settle();
        chk(rise_pos == 516, "R5", rise_pos, 516);
        rise_pos = -1;
        run_field(1, 0, 0, -1, 0);
        settle();
        chk(rise_pos == 518, "R5", rise_pos, 518);

        // R8: change offset partway through the field
        cur_tag = "R8";
        set_cfg(0, 10, 0, 0, 0, 0, 0);
        rise_pos = -1;
        run_field(0, 0, 0, 5, 0);
        settle();
        chk(rise_pos == 28, "R8", rise_pos, 28);

        // R10: start and end on the same half-line
        cur_tag = "R10";
        rise_pos = -1; fall_pos = -1;
        run_field(1, 0, 0, -1, 0);
        settle();
        chk(vs_out == 1, "R10", int'(vs_out), 1);
        chk(fall_pos == -1, "R10", fall_pos, -1);

        // R2 R3 R4: sweep sign, offset and both delays, alternating fields
        cur_tag = "R2";
        for (int k = 0; k < 256; k++) begin
            int adv = k & 1, ld = (k >> 1) & 1, hd = (k >> 2) & 1, ofs = k >> 3;
            int odd = (k >> 1) & 1 ^ (k & 1) ^ (k >> 3) & 1;
            if (odd != 0) set_cfg(adv, ofs, ld, 1 - ld, hd, 1 - hd, ofs % 4);
            else          set_cfg(adv, ofs, 1 - ld, ld, 1 - hd, hd, ofs % 4);
            run_field(odd, 0, 0, -1, 0);
        end
        settle();
        chk(exp_q.size() == 0, "R2", exp_q.size(), 0);

        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule